// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

The block walks an 8x8 key matrix one crossing per clock. A six-bit step counter supplies a row field (upper three bits) and a column field (lower three bits). The block drives the selected row high, one-hot, and samples the matching column sense input. It gathers the 64 results of one pass into a frame. Each frame is compared with the frame before it. An 8-bit counter loaded from a software preload climbs on every matching frame. The first time the counter reaches 0xFF after a reload, the frame is latched as the debounced key state and an interrupt goes pending.

A single 32-bit control register sets the behaviour:
- Scanning can be turned on or off.
- A fast mode steps the counter by eight, so only column 0 of each row is visited.
- A back-drive indication can be turned on for the pad logic.
- A probe mode stops scanning and senses one software-chosen crossing directly.
- The three-key reset request can be switched off.

The three-key reset request goes to a watchdog. It is raised while the debounced state holds exactly three parameter-chosen keys.

Top module: `keypad_scanner`

## Requirements
- R1: With control bit 18 set and bit 9 clear, the counter visits key codes 0..63 (code = row*8 + column), one code per clock. `row_drive` is one-hot on the row of the current code. `col_sense[column]` is sampled as that key's state, and the 64 samples of a pass make one frame. When bit 18 is clear and bit 9 is clear, `row_drive` is 0 and the counter restarts at code 0.
- R2: When a frame completes, it is compared with the stored reference. If they are equal, the debounce counter increments, saturating at 0xFF. If they differ, the frame becomes the new reference and the counter is loaded from control bits [7:0].
- R3: When the counter reaches 0xFF for the first time since the last reload, `key_state` takes that frame and `key_irq` is set, both one clock after the frame completes. A preload of 0xFC fires on the third matching frame after the reference frame. A preload of 0xFF fires on the reference frame itself.
- R4: `key_irq` stays high until a clock with `irq_clear` high; a new event on the same edge wins. Further frames equal to the latched one never raise it again.
- R5: With control bit 11 set, the counter steps by 8, so a pass takes 8 clocks. Only column-0 codes are sampled, and every other bit of the frame is 0.
- R6: `trio_reset` is high one clock after `key_state` equals exactly the set {KEY_A, KEY_B, KEY_C} (defaults 3, 12, 45), provided control bit 8 is 0. It is low when that bit is 1 or when any other key is in the set.
- R7: With control bit 9 set, scanning stops. `row_drive` is one-hot on the row of the code in control bits [17:12]. `probe_hit` shows, one clock later, the undebounced `col_sense` bit of that code's column. `key_state` is left unchanged. Outside this mode `probe_hit` is 0.
- R8: `back_drive` is high while scanning with control bit 10 set and the column field of the current code is 0 or 1.
- R9: The control register resets to 0x00000000. A write replaces all 32 bits, and `cfg_rdata` returns every written bit, including bits no function uses.
- R10: After reset, `row_drive`, `back_drive`, `key_state`, `key_irq`, `trio_reset` and `probe_hit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register contents |
| irq_clear | input | 1 | Clears the pending key interrupt |
| row_drive | output | ROWS | One-hot row select to the matrix |
| col_sense | input | COLS | Column sense inputs from the matrix |
| back_drive | output | 1 | Request to drive rows and columns high |
| key_state | output | ROWS*COLS | Debounced key bitmap, bit = row*COLS + column |
| key_irq | output | 1 | Pending key event interrupt |
| trio_reset | output | 1 | Three-key reset request to the watchdog |
| probe_hit | output | 1 | Undebounced key state in probe mode |

## Verification
The bench runs its own frame model and hunts the debounce edges:
- A preload of 0xFC, where a counter that fired one frame early or late shows up at once.
- A preload of 0xFF, which must fire on the reload itself; a design that fired only on increments would never interrupt.
- Interrupt clears with keys held, where a design without the first-time guard would re-raise.

It also checks that fast mode zeroes the frame bits it skips, since leftovers from an earlier full scan would leak into `key_state`. It checks that a fourth key or the disable bit removes the three-key request. It checks that probe mode neither disturbs the debounced state nor reads the wrong crossing.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int PRE_W   = 8;
  localparam int CF_NO3K = 8;
  localparam int CF_DIAG = 9;
  localparam int CF_BDRV = 10;
  localparam int CF_FAST = 11;
  localparam int CF_ADDR = 12;
  localparam int CF_EN   = 18;

  typedef struct packed {
    logic             en;
    logic             fast;
    logic             bdrv;
    logic             probe;
    logic             no3k;
    logic [PRE_W-1:0] preload;
  } kps_cfg_t;
endpackage

// File: rtl/kps_scan.sv
module kps_scan #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int N     = ROWS * COLS,
  localparam int RC_W  = $clog2(N),
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = RC_W - COL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_en,
  input  logic            fast,
  input  logic            bdrv,
  input  logic [COLS-1:0] col_in,
  output logic [ROWS-1:0] row_sel,
  output logic            bd,
  output logic [N-1:0]    frame,
  output logic            frame_vld
);
  logic [RC_W-1:0] rc, rc_nx, step;
  logic [N-1:0]    acc, acc_w, col0_mask;
  logic [ROW_W-1:0] rc_row;
  logic [COL_W-1:0] rc_col;

  assign rc_row = rc[RC_W-1:COL_W];
  assign rc_col = rc[COL_W-1:0];
  assign step   = fast ? RC_W'(COLS) : RC_W'(1);
  assign rc_nx  = rc + step;

  genvar g;
  generate
    for (g = 0; g < ROWS; g++) begin : g_row
      assign row_sel[g] = scan_en && (rc_row == ROW_W'(g));
    end
    for (g = 0; g < N; g++) begin : g_mask
      assign col0_mask[g] = ((g % COLS) == 0);
    end
  endgenerate

  assign bd = scan_en && bdrv && (rc_col < COL_W'(2));

  always_comb begin
    acc_w     = acc;
    acc_w[rc] = col_in[rc_col];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rc        <= '0;
      acc       <= '0;
      frame     <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (!scan_en) begin
        rc <= '0;
      end else begin
        rc  <= rc_nx;
        acc <= acc_w;
        if (rc_nx == '0) begin
          frame     <= fast ? (acc_w & col0_mask) : acc_w;
          frame_vld <= 1'b1;
        end
      end
    end
  end

  assert_row_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));
  assert_fast_col0_R5: assert property (@(posedge clk) disable iff (rst)
    (scan_en && fast && rc_col == '0) |=> (rc_col == '0));
endmodule

// File: rtl/kps_debounce.sv
module kps_debounce #(
  parameter int N = 64,
  localparam int PW = kps_pkg::PRE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_vld,
  input  logic [N-1:0]  frame,
  input  logic [PW-1:0] preload,
  input  logic          irq_clr,
  output logic [N-1:0]  keys,
  output logic          irq
);
  localparam logic [PW-1:0] TERM = '1;

  logic [N-1:0]  ref_q;
  logic [PW-1:0] cnt, cnt_nx;
  logic          done, match, fire;

  assign match  = (frame == ref_q);
  assign cnt_nx = match ? ((cnt == TERM) ? cnt : cnt + 1'b1) : preload;
  assign fire   = frame_vld && (cnt_nx == TERM) && !(match && done);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      keys  <= '0;
      irq   <= 1'b0;
    end else begin
      if (frame_vld) begin
        cnt  <= cnt_nx;
        done <= fire || (match && done);
        if (!match) ref_q <= frame;
      end
      if (fire) keys <= frame;
      irq <= fire || (irq && !irq_clr);
    end
  end

  assert_irq_source_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(frame_vld));
  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && frame != ref_q) |=> (cnt == $past(preload)));
  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/kps_trio.sv
module kps_trio #(
  parameter int N     = 64,
  parameter int KEY_A = 3,
  parameter int KEY_B = 12,
  parameter int KEY_C = 45
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] keys,
  input  logic         dis,
  output logic         req
);
  logic [N-1:0] trio;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_trio
      assign trio[g] = (g == KEY_A) || (g == KEY_B) || (g == KEY_C);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= !dis && (keys == trio);
  end

  assert_trio_count_R6: assert property (@(posedge clk) disable iff (rst)
    req |-> ($countones($past(keys)) == 3));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int KEY_A = 3,
  parameter int KEY_B = 12,
  parameter int KEY_C = 45,
  localparam int N     = ROWS * COLS,
  localparam int RC_W  = $clog2(N),
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = RC_W - COL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            irq_clear,
  output logic [ROWS-1:0] row_drive,
  input  logic [COLS-1:0] col_sense,
  output logic            back_drive,
  output logic [N-1:0]    key_state,
  output logic            key_irq,
  output logic            trio_reset,
  output logic            probe_hit
);
  import kps_pkg::*;

  logic [31:0]     ctrl;
  kps_cfg_t        cfg;
  logic [RC_W-1:0] paddr;
  logic [ROW_W-1:0] prow;
  logic [COL_W-1:0] pcol;
  logic            scan_en, fvld;
  logic [ROWS-1:0] scan_rows, probe_rows;
  logic [N-1:0]    frame;

  always_ff @(posedge clk) begin
    if (rst)         ctrl <= '0;
    else if (cfg_we) ctrl <= cfg_wdata;
  end
  assign cfg_rdata = ctrl;

  assign cfg.preload = ctrl[PRE_W-1:0];
  assign cfg.no3k    = ctrl[CF_NO3K];
  assign cfg.probe   = ctrl[CF_DIAG];
  assign cfg.bdrv    = ctrl[CF_BDRV];
  assign cfg.fast    = ctrl[CF_FAST];
  assign cfg.en      = ctrl[CF_EN];
  assign paddr       = ctrl[CF_ADDR +: RC_W];
  assign prow        = paddr[RC_W-1:COL_W];
  assign pcol        = paddr[COL_W-1:0];
  assign scan_en     = cfg.en && !cfg.probe;

  genvar g;
  generate
    for (g = 0; g < ROWS; g++) begin : g_probe
      assign probe_rows[g] = (prow == ROW_W'(g));
    end
  endgenerate

  assign row_drive = cfg.probe ? probe_rows : scan_rows;

  always_ff @(posedge clk) begin
    if (rst) probe_hit <= 1'b0;
    else     probe_hit <= cfg.probe && col_sense[pcol];
  end

  kps_scan #(.ROWS(ROWS), .COLS(COLS)) u_scan (
    .clk(clk), .rst(rst), .scan_en(scan_en), .fast(cfg.fast), .bdrv(cfg.bdrv),
    .col_in(col_sense), .row_sel(scan_rows), .bd(back_drive),
    .frame(frame), .frame_vld(fvld)
  );

  kps_debounce #(.N(N)) u_db (
    .clk(clk), .rst(rst), .frame_vld(fvld), .frame(frame),
    .preload(cfg.preload), .irq_clr(irq_clear), .keys(key_state), .irq(key_irq)
  );

  kps_trio #(.N(N), .KEY_A(KEY_A), .KEY_B(KEY_B), .KEY_C(KEY_C)) u_trio (
    .clk(clk), .rst(rst), .keys(key_state), .dis(cfg.no3k), .req(trio_reset)
  );

  assert_probe_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg.probe && $past(cfg.probe) && $past(cfg.probe, 2)) |-> $stable(key_state));
  assert_probe_row_R7: assert property (@(posedge clk) disable iff (rst)
    cfg.probe |-> $onehot(row_drive));
endmodule

// File: tb/tb_keypad_scanner.sv
`timescale 1ns/1ps
module tb_keypad_scanner;
  localparam int ROWS = 8, COLS = 8, N = 64;
  localparam int KA = 3, KB = 12, KC = 45;
  localparam logic [31:0] EN = 32'h1 << 18, FAST = 32'h1 << 11, BD = 32'h1 << 10;
  localparam logic [31:0] DIAG = 32'h1 << 9, NO3K = 32'h1 << 8;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, irq_clear = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [ROWS-1:0] row_drive;
  logic [COLS-1:0] col_sense;
  logic back_drive, key_irq, trio_reset, probe_hit;
  logic [N-1:0] key_state;
  logic [N-1:0] keymat = 0;

  always #2 clk = ~clk;

  keypad_scanner dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_clear(irq_clear), .row_drive(row_drive), .col_sense(col_sense),
    .back_drive(back_drive), .key_state(key_state), .key_irq(key_irq),
    .trio_reset(trio_reset), .probe_hit(probe_hit)
  );

  always_comb begin
    col_sense = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (row_drive[r] && keymat[r*COLS+c]) col_sense[c] = 1'b1;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ctrl;
  int          m_rc, m_cnt;
  logic [N-1:0] m_acc, m_frame, m_ref, m_keys, col0, trio;
  logic m_fv, m_done, m_irq, m_rst3, m_hit;

  initial for (int i = 0; i < N; i++) begin
    col0[i] = (i % COLS == 0);
    trio[i] = (i == KA) || (i == KB) || (i == KC);
  end

  always @(posedge clk) begin
    logic n_rst3, n_hit, fire;
    int stride;
    if (rst) begin
      m_ctrl = 0; m_rc = 0; m_cnt = 0; m_acc = 0; m_frame = 0; m_ref = 0; m_keys = 0;
      m_fv = 0; m_done = 0; m_irq = 0; m_rst3 = 0; m_hit = 0;
    end else begin
      n_rst3 = !m_ctrl[8] && (m_keys == trio);
      n_hit  = m_ctrl[9] ? keymat[m_ctrl[17:12]] : 1'b0;
      fire = 0;
      if (m_fv) begin
        if (m_frame == m_ref) begin
          if (m_cnt != 255) m_cnt++;
          fire = (m_cnt == 255) && !m_done;
        end else begin
          m_ref = m_frame; m_cnt = int'(m_ctrl[7:0]); m_done = 0;
          fire = (m_cnt == 255);
        end
        if (fire) begin m_keys = m_frame; m_done = 1; end
      end
      m_irq = fire ? 1'b1 : (irq_clear ? 1'b0 : m_irq);
      m_fv = 0;
      if (m_ctrl[18] && !m_ctrl[9]) begin
        m_acc[m_rc] = keymat[m_rc];
        stride = m_ctrl[11] ? COLS : 1;
        if (m_rc + stride >= N) begin
          m_frame = m_ctrl[11] ? (m_acc & col0) : m_acc;
          m_fv = 1; m_rc = 0;
        end else m_rc = m_rc + stride;
      end else m_rc = 0;
      m_rst3 = n_rst3; m_hit = n_hit;
      if (cfg_we) m_ctrl = cfg_wdata;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    logic [ROWS-1:0] er;
    logic eb;
    if (!rst) begin
      if (m_ctrl[9]) er = ROWS'(1) << (m_ctrl[17:12] / COLS);
      else if (m_ctrl[18]) er = ROWS'(1) << (m_rc / COLS);
      else er = '0;
      eb = m_ctrl[18] && !m_ctrl[9] && m_ctrl[10] && ((m_rc % COLS) < 2);
      chk(row_drive == er, "R1 row_drive", 64'(row_drive), 64'(er));
      chk(back_drive == eb, "R8 back_drive", 64'(back_drive), 64'(eb));
      chk(key_state == m_keys, "R2 key_state", key_state, m_keys);
      chk(key_irq == m_irq, "R4 key_irq", 64'(key_irq), 64'(m_irq));
      chk(trio_reset == m_rst3, "R6 trio_reset", 64'(trio_reset), 64'(m_rst3));
      chk(probe_hit == m_hit, "R7 probe_hit", 64'(probe_hit), 64'(m_hit));
      chk(cfg_rdata == m_ctrl, "R9 cfg_rdata", 64'(cfg_rdata), 64'(m_ctrl));
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic clr_irq();
    @(negedge clk); irq_clear = 1;
    @(negedge clk); irq_clear = 0;
  endtask
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_irq(input int lim, output int took);
    took = 0;
    while (!key_irq && took < lim) begin @(negedge clk); took++; end
  endtask

  function automatic logic [N-1:0] bits3(input int a, input int b, input int c);
    logic [N-1:0] v = 0;
    if (a >= 0) v[a] = 1;
    if (b >= 0) v[b] = 1;
    if (c >= 0) v[c] = 1;
    return v;
  endfunction

  initial begin
    repeat (15000 * 10) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t, cnt_bd, cnt_r0;
    logic [N-1:0] exp;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 / R9 reset state
    chk({row_drive, back_drive, key_irq, trio_reset, probe_hit} == 0, "R10 reset outputs", 64'(row_drive), 0);
    chk(key_state == 0, "R10 reset keys", key_state, 0);
    chk(cfg_rdata == 0, "R9 reset ctrl", 64'(cfg_rdata), 0);

    // normal scan, preload 0xFC, back-drive, unused bits written
    keymat = bits3(9, 20, 63);
    wr(32'hA5000000 | EN | BD | 32'hFC);
    chk(cfg_rdata == (32'hA5000000 | EN | BD | 32'hFC), "R9 readback", 64'(cfg_rdata), 64'(32'hA50404FC));
    cnt_bd = 0; cnt_r0 = 0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      cnt_bd += back_drive; cnt_r0 += (row_drive == 8'h01);
    end
    chk(cnt_bd == 16, "R8 back_drive per pass", 64'(cnt_bd), 16);
    chk(cnt_r0 == 8, "R1 row 0 clocks per pass", 64'(cnt_r0), 8);
    wait_irq(1000, t);
    chk(key_irq, "R3 irq after 0xFC debounce", 64'(key_irq), 1);
    chk(key_state == bits3(9, 20, 63), "R3 latched keys", key_state, bits3(9, 20, 63));

    // R4 clear and no re-raise with keys held
    clr_irq();
    run(5 * N);
    chk(!key_irq, "R4 no re-raise", 64'(key_irq), 0);

    // R6 trio
    keymat = bits3(KA, KB, KC);
    wait_irq(1000, t);
    run(2);
    chk(key_state == trio, "R6 trio keys", key_state, trio);
    chk(trio_reset, "R6 trio asserted", 64'(trio_reset), 1);
    clr_irq();
    wr(EN | NO3K | 32'hFC);
    run(2);
    chk(!trio_reset, "R6 disable bit", 64'(trio_reset), 0);
    wr(EN | 32'hFC);
    run(2);
    chk(trio_reset, "R6 re-enabled", 64'(trio_reset), 1);
    keymat = bits3(KA, KB, KC) | bits3(50, -1, -1);
    wait_irq(1000, t);
    run(2);
    chk(!trio_reset, "R6 fourth key blocks", 64'(trio_reset), 0);
    clr_irq();

    // R5 fast mode
    wr(32'hFC);
    keymat = bits3(16, 21, -1);
    wr(EN | FAST | 32'hFC);
    wait_irq(200, t);
    chk(key_irq, "R5 fast irq", 64'(key_irq), 1);
    chk(key_state == bits3(16, -1, -1), "R5 fast col0 only", key_state, bits3(16, -1, -1));
    clr_irq();

    // R3 preload 0xFF fires on reload frame
    wr(32'hFF);
    keymat = bits3(7, -1, -1);
    run(2);
    wr(EN | 32'hFF);
    wait_irq(200, t);
    chk(key_irq && t <= N + 2, "R3 preload 0xFF latency", 64'(t), 64'(N + 2));
    chk(key_state == bits3(7, -1, -1), "R3 preload 0xFF keys", key_state, bits3(7, -1, -1));
    clr_irq();

    // R7 probe mode
    exp = key_state;
    wr(DIAG | (32'd7 << 12));
    run(2);
    chk(probe_hit, "R7 probe pressed", 64'(probe_hit), 1);
    wr(DIAG | (32'd8 << 12));
    run(2);
    chk(!probe_hit, "R7 probe idle", 64'(probe_hit), 0);
    keymat = bits3(30, -1, -1);
    run(3 * N);
    chk(key_state == exp, "R7 keys frozen", key_state, exp);
    chk(!key_irq, "R7 no irq in probe", 64'(key_irq), 0);
    wr(0);
    run(2);
    chk(row_drive == 0, "R1 disabled rows", 64'(row_drive), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule